// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block sets the bit rate of an I2C controller's SCL line. A prescaler divides the system clock by a programmable factor to make an internal tick. A phase counter then times each SCL period in those ticks. The period is split into a low phase and a high phase. The high phase carries a small extra count that makes up for rise time, fall time and internal delay on the wire.

The block drives SCL only through an open-drain pull request. Once it releases the line, it waits until the synchronised SCL input reads high before it starts timing the high phase. A target that holds SCL low therefore stretches the period without upsetting the timing. The byte engine receives three one-cycle strobes: the start of the low phase, the start of the high phase, and a sample point in the middle of the high phase.

A single configuration word holds both the divider field and the period field. The width of the divider field is a parameter, and it moves the period field up or down in the word. A word written while the block runs is held back and takes effect at the next start of a low phase. All control pins are plain levels or pulses, with no handshake.

Top module: `scl_rate_gen`

## Requirements
- R1: The configuration word holds the divider value `cdf` in bits [CDF_W-1:0] and the period value `scgd` (6 bits) in bits [CDF_W+5:CDF_W]. Every internal tick spans exactly cdf+1 clock cycles, counted from the start of the current phase.
- R2: Each low phase holds `scl_pull` high for exactly (10 + 4·scgd)·(cdf+1) clock cycles.
- R3: With no stretching, SCL stays high from the first cycle it reads high until `scl_pull` rises again for exactly 3 + (10 + 4·scgd + comp)·(cdf+1) cycles, where `comp` is `comp_cnt` and 3 is the two-flop synchroniser plus one state cycle.
- R4: If SCL is held low for S extra cycles after release, the high phase timing is unchanged, measured from the cycle SCL first reads high. No high strobe or sample strobe occurs while the line is held.
- R5: `sample_stb` pulses once per high phase, at cycle index 2 + floor((10 + 4·scgd + comp)/2)·(cdf+1), where index 0 is the first cycle SCL reads high.
- R6: `low_stb` is a one-cycle pulse in the first cycle of each low phase. `high_stb` is a one-cycle pulse at index 3 of the high window, the first cycle of high-phase counting.
- R7: A configuration write made during a high phase does not change that high phase. The next low phase and everything after it use the new word.
- R8: With `en` low, `scl_pull` is low from the next cycle on and no strobe fires. When `en` rises, a low phase starts in the next cycle and uses the latest word written.
- R9: During and after reset, with `en` low, `scl_pull` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle with SCL released |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | CDF_W+6 | Configuration word {scgd, cdf} |
| comp_cnt | input | COMP_W | Rise/fall compensation count added to the high phase |
| scl_in | input | 1 | Raw SCL line level (asynchronous) |
| scl_pull | output | 1 | 1 = pull SCL low |
| low_stb | output | 1 | First cycle of a low phase |
| high_stb | output | 1 | First cycle of high-phase counting |
| sample_stb | output | 1 | Mid-high sample point |

## Verification
A prescaler or phase counter that lands in the wrong state changes the length of the very next low or high window, so the bench times every window to the exact cycle against closed-form lengths. A faulty synchroniser or stretch gate shows up as a wrong high-window length, or as a strobe fired while the bench holds the line low, and this is visible within one SCL period. Errors in config staging appear one period later, when the bench checks that the old timing holds for the current window and the new timing applies to the next one.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int SCGD_W    = 6;
  localparam int BASE_HALF = 10;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CDF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CDF_W-1:0] cdf,
  output logic             tick
);
  logic [CDF_W-1:0] pre_q;

  assign tick = (pre_q == cdf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_q <= '0;
    else if (restart || tick) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  // R1
  pre_le_cdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (pre_q <= $past(cdf)) || $past(cdf) != cdf);
endmodule

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[i] <= 1'b0;
        else        sh[i] <= sh[i-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg import scl_div_pkg::*; #(
  parameter int CDF_W  = 3,
  parameter int COMP_W = 4,
  localparam int CFG_W = CDF_W + SCGD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [COMP_W-1:0] comp_in,
  input  logic              load,
  output logic [CDF_W-1:0]  cdf_o,
  output logic [SCGD_W-1:0] scgd_o,
  output logic [COMP_W-1:0] comp_o
);
  logic [CFG_W-1:0] pend_q;
  logic [CFG_W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= '0;
    else if (wr_en) pend_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      comp_o <= '0;
    end else if (load) begin
      act_q  <= pend_q;
      comp_o <= comp_in;
    end
  end

  assign cdf_o  = act_q[CDF_W-1:0];
  assign scgd_o = act_q[CFG_W-1:CDF_W];

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q) && $stable(comp_o));
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr import scl_div_pkg::*; #(
  parameter int COMP_W = 4,
  localparam int CNT_W = $clog2(BASE_HALF + 4 * (2**SCGD_W - 1) + 2**COMP_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              scl_hi,
  input  logic [SCGD_W-1:0] scgd,
  input  logic [COMP_W-1:0] comp,
  output phase_e            phase_q,
  output phase_e            phase_d,
  output logic              scl_pull,
  output logic              low_stb,
  output logic              high_stb,
  output logic              sample_stb
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] high_len;
  logic [CNT_W-1:0] mid_pt;
  logic             low_done;
  logic             high_done;

  assign low_len   = CNT_W'(BASE_HALF) + (CNT_W'(scgd) << 2);
  assign high_len  = low_len + CNT_W'(comp);
  assign mid_pt    = (high_len >> 1) - 1'b1;
  assign low_done  = tick && (cnt_q == low_len - 1'b1);
  assign high_done = tick && (cnt_q == high_len - 1'b1);

  always_comb begin
    phase_d = phase_q;
    if (!en) phase_d = PH_IDLE;
    else begin
      unique case (phase_q)
        PH_IDLE: phase_d = PH_LOW;
        PH_LOW:  if (low_done)  phase_d = PH_WAIT;
        PH_WAIT: if (scl_hi)    phase_d = PH_HIGH;
        PH_HIGH: if (high_done) phase_d = PH_LOW;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      low_stb  <= (phase_d == PH_LOW)  && (phase_q != PH_LOW);
      high_stb <= (phase_d == PH_HIGH) && (phase_q != PH_HIGH);
      if (phase_d != phase_q) cnt_q <= '0;
      else if (tick)          cnt_q <= cnt_q + 1'b1;
    end
  end

  assign scl_pull   = (phase_q == PH_LOW);
  assign sample_stb = (phase_q == PH_HIGH) && tick && (cnt_q == mid_pt);

  // R2
  low_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q < low_len));
  // R3
  high_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH) |-> (cnt_q < high_len));
  // R4
  high_after_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_stb |-> (phase_q == PH_HIGH) && $past(scl_hi));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_stb, high_stb, sample_stb}));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen import scl_div_pkg::*; #(
  parameter int CDF_W       = 3,
  parameter int COMP_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = CDF_W + SCGD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [COMP_W-1:0] comp_cnt,
  input  logic              scl_in,
  output logic              scl_pull,
  output logic              low_stb,
  output logic              high_stb,
  output logic              sample_stb
);
  logic              tick;
  logic              scl_hi;
  logic              load;
  logic              restart;
  phase_e            phase_q;
  phase_e            phase_d;
  logic [CDF_W-1:0]  cdf_a;
  logic [SCGD_W-1:0] scgd_a;
  logic [COMP_W-1:0] comp_a;

  assign load    = (phase_q == PH_IDLE) || (phase_d == PH_LOW && phase_q != PH_LOW);
  assign restart = (phase_d != phase_q) || (phase_q == PH_IDLE);

  scl_cfg_reg #(.CDF_W(CDF_W), .COMP_W(COMP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .comp_in(comp_cnt), .load(load),
    .cdf_o(cdf_a), .scgd_o(scgd_a), .comp_o(comp_a)
  );

  scl_prescaler #(.CDF_W(CDF_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cdf(cdf_a), .tick(tick)
  );

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_hi)
  );

  scl_phase_ctr #(.COMP_W(COMP_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .scl_hi(scl_hi),
    .scgd(scgd_a), .comp(comp_a), .phase_q(phase_q), .phase_d(phase_d),
    .scl_pull(scl_pull), .low_stb(low_stb), .high_stb(high_stb),
    .sample_stb(sample_stb)
  );

  // R8
  en_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_pull && !high_stb && !sample_stb);
  // R6
  low_stb_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_stb |-> scl_pull && !$past(scl_pull));
  // R4
  no_sample_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |-> !sample_stb && !high_stb);
endmodule

// File: tb/scl_rate_gen_test.sv
`timescale 1ns/1ps
module scl_rate_gen_test;
  localparam int CW = 3;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cfg_we = 1'b0;
  logic [CW+5:0] cfg_wdata = '0;
  logic [RW-1:0] comp_cnt = '0;
  logic hold = 1'b0;
  logic scl_pull, low_stb, high_stb, sample_stb;
  wire  scl_line = ~scl_pull & ~hold;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scl_rate_gen #(.CDF_W(CW), .COMP_W(RW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .comp_cnt(comp_cnt), .scl_in(scl_line), .scl_pull(scl_pull),
    .low_stb(low_stb), .high_stb(high_stb), .sample_stb(sample_stb)
  );

  function automatic int exp_low(int sg, int cd);
    return (10 + 4 * sg) * (cd + 1);
  endfunction
  function automatic int exp_high(int sg, int cd, int r);
    return 3 + (10 + 4 * sg + r) * (cd + 1);
  endfunction
  function automatic int exp_samp(int sg, int cd, int r);
    return 2 + ((10 + 4 * sg + r) / 2) * (cd + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int sg, input int cd);
    cfg_wdata = (CW+6)'((sg << CW) | cd);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_run();
    en = 1'b1;
    @(negedge clk);
    chk("R8 pull one cycle after enable", int'(scl_pull), 1);
  endtask

  task automatic stop_run();
    int stray = 0;
    en = 1'b0;
    @(negedge clk);
    chk("R8 release after disable", int'(scl_pull), 0);
    for (int i = 0; i < 12; i++) begin
      if (scl_pull || low_stb || high_stb || sample_stb) stray++;
      @(negedge clk);
    end
    chk("R8 quiet while disabled", stray, 0);
  endtask

  // Entered at the negedge of the first low-phase cycle; leaves at the next one.
  task automatic do_period(input int sg, input int cd, input int r, input int s,
                           input bit midw, input int msg, input int mcd);
    int lowc = 0;
    int hc = 0;
    int samp = -1;
    int hs = -1;
    int nsamp = 0;
    int stray = 0;
    chk("R6 low_stb at low start", int'(low_stb), 1);
    while (scl_pull) begin
      lowc++;
      @(negedge clk);
    end
    chk("R2 low window (R1 prescale)", lowc, exp_low(sg, cd));
    if (s > 0) begin
      hold = 1'b1;
      for (int i = 0; i < s; i++) begin
        if (high_stb || sample_stb) stray++;
        @(negedge clk);
      end
      hold = 1'b0;
      chk("R4 no strobe while stretched", stray, 0);
    end
    while (!scl_pull) begin
      if (sample_stb) begin samp = hc; nsamp++; end
      if (high_stb) hs = hc;
      if (midw && hc == 5) begin
        cfg_wdata = (CW+6)'((msg << CW) | mcd);
        cfg_we = 1'b1;
      end else cfg_we = 1'b0;
      hc++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    if (s > 0) chk("R4 high window after stretch", hc, exp_high(sg, cd, r));
    else       chk("R3 high window", hc, exp_high(sg, cd, r));
    chk("R5 sample point", samp, exp_samp(sg, cd, r));
    chk("R5 single sample pulse", nsamp, 1);
    chk("R6 high_stb index", hs, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R9 pull in reset", int'(scl_pull), 0);
    chk("R9 strobes in reset", int'(low_stb | high_stb | sample_stb), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle after reset", int'(scl_pull | low_stb | high_stb | sample_stb), 0);

    // directed: smallest period
    comp_cnt = 0;
    wr_cfg(0, 0);
    start_run();
    do_period(0, 0, 0, 0, 1'b0, 0, 0);
    do_period(0, 0, 0, 0, 1'b0, 0, 0);
    stop_run();

    // directed: largest period, widest divider (R1 field split at top bits)
    comp_cnt = 15;
    wr_cfg(63, 7);
    start_run();
    do_period(63, 7, 15, 0, 1'b0, 0, 0);
    stop_run();

    // directed: R7 mid-high reconfiguration
    comp_cnt = 3;
    wr_cfg(2, 1);
    start_run();
    do_period(2, 1, 3, 0, 1'b1, 5, 3);
    do_period(5, 3, 3, 0, 1'b0, 0, 0);
    do_period(5, 3, 3, 7, 1'b0, 0, 0);

    // directed: disable in the middle of a low phase
    repeat (4) @(negedge clk);
    stop_run();

    // random configurations with random stretching
    for (int it = 0; it < 12; it++) begin
      int sg = $urandom_range(15, 0);
      int cd = $urandom_range(7, 0);
      int r  = $urandom_range(15, 0);
      int s  = $urandom_range(20, 0);
      comp_cnt = RW'(r);
      wr_cfg(sg, cd);
      start_run();
      do_period(sg, cd, r, 0, 1'b0, 0, 0);
      do_period(sg, cd, r, s, 1'b0, 0, 0);
      stop_run();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule